// File: doc/BRIEF.md
# Two-wide in-order pairing and issue controller

This block is the issue stage of a two-wide in-order pipeline. Each cycle it looks at the two oldest decoded entries of an instruction window. It then decides whether both issue, only the older one issues, or nothing issues. The older entry always occupies slot 0. The younger entry can only ever occupy slot 1.

Each entry carries the following fields:
- a class code;
- a destination register, with a write flag;
- two source registers;
- for block transfers, a register count.

An internal scoreboard tracks when each register's pending result becomes usable. There are separate readiness times for ordinary operand use and for use as a memory address.

Block transfers occupy slot 0 for several beats. The window holds still until the final beat. Only on that final beat may a younger entry pair with the transfer.

The controller reports three things:
- the two issue strobes;
- how far the window should advance, which is 0, 1 or 2.

Top module: `dual_issue_ctrl`

## Requirements
- R1: Class codes are 0 ALU, 1 load/store, 2 multiply, 3 branch, 4 block transfer. `s1_issue_o` is never high without `s0_issue_o`. A lone issue always uses slot 0. `adv_o` equals the number of entries that completed issue.
- R2: At most one memory-class entry issues per cycle. Codes 1 and 4 are both memory class. Load/store pairs with a non-memory entry in either slot.
- R3: A multiply (code 2) never issues in slot 1. As the younger entry it waits, including behind another multiply. A multiply in slot 0 can pair with an ALU entry.
- R4: At most one branch (code 3) issues per cycle, in either slot.
- R5: Two entries that both write the same destination register never issue together. If the younger entry has its write flag clear, the shared register number does not block pairing.
- R6: An entry waits while any of its sources is pending in the scoreboard. Slot 1 cannot issue when it reads the register that slot 0 writes in the same cycle.
- R7: An ALU result can be read by a non-address consumer in the cycle after issue. When that result is used as an address (`srca` of codes 1 or 4), the consumer waits two cycles and issues in the third cycle after the producer. A multiply result can be read by an ALU entry two cycles after issue.
- R8: A block transfer (code 4) never issues in slot 1.
- R9: A block transfer moving N registers takes 1 + floor(N/2) beats. On every beat slot 0 issues. `adv_o` is 0 until the last beat, and only the last beat may pair with the younger entry.
- R10: While `stall_i` is high, nothing issues, `adv_o` is 0, and an ongoing block transfer keeps its remaining beat count.
- R11: When slot 0 is not valid and no block transfer is active, nothing issues. Reset clears the scoreboard and the beat counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stall_i | input | 1 | Downstream stall; blocks all issue |
| i0_vld_i | input | 1 | Older window entry valid |
| i0_cls_i | input | 3 | Older entry class code |
| i0_dst_i | input | 4 | Older entry destination register |
| i0_wr_i | input | 1 | Older entry writes its destination |
| i0_srca_i | input | 4 | Older entry source A (address for memory classes) |
| i0_srcb_i | input | 4 | Older entry source B |
| i0_nreg_i | input | 4 | Register count of a block transfer |
| i1_vld_i | input | 1 | Younger window entry valid |
| i1_cls_i | input | 3 | Younger entry class code |
| i1_dst_i | input | 4 | Younger entry destination register |
| i1_wr_i | input | 1 | Younger entry writes its destination |
| i1_srca_i | input | 4 | Younger entry source A |
| i1_srcb_i | input | 4 | Younger entry source B |
| s0_issue_o | output | 1 | Slot 0 issues this cycle |
| s1_issue_o | output | 1 | Slot 1 issues this cycle |
| adv_o | output | 2 | Window advance count |

## Verification
The hardest case to reach is the last beat of a block transfer that was interrupted by a downstream stall. To get there, the block must be several beats into the transfer when the stall arrives, and the younger entry must then be judged against the transfer's own fields.

The stimulus works as follows:
- It holds a four-register transfer in slot 0, with an ALU entry behind it.
- It raises the stall between the first and second beats.
- It checks that the beat count survives the stall, and that pairing happens only on the third beat.

A second transfer with a younger load/store confirms that the last-beat pairing still respects the single memory slot.

// File: rtl/dual_issue_pkg.sv
package dual_issue_pkg;
  typedef enum logic [2:0] {
    CLS_ALU = 3'd0,
    CLS_LS  = 3'd1,
    CLS_MUL = 3'd2,
    CLS_BR  = 3'd3,
    CLS_BLK = 3'd4
  } iclass_e;

  function automatic logic is_mem(input logic [2:0] c);
    return (c == CLS_LS) || (c == CLS_BLK);
  endfunction
endpackage

// File: rtl/dual_issue_scoreboard.sv
module dual_issue_scoreboard
  import dual_issue_pkg::*;
#(
  parameter int NREG        = 16,
  parameter int TW          = 2,
  parameter int LAT_ALU_GEN = 1,
  parameter int LAT_ALU_ADR = 3,
  parameter int LAT_LD_GEN  = 2,
  parameter int LAT_LD_ADR  = 3,
  parameter int LAT_MUL_GEN = 2,
  parameter int LAT_MUL_ADR = 3,
  localparam int RW = $clog2(NREG)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [1:0]           wr_en_i,
  input  logic [1:0][RW-1:0]   wr_reg_i,
  input  logic [1:0][2:0]      wr_cls_i,
  input  logic [3:0][RW-1:0]   rd_reg_i,
  input  logic [3:0]           rd_adr_i,
  output logic [3:0]           rd_rdy_o
);
  localparam logic [TW-1:0] T_ALU_G = TW'(LAT_ALU_GEN - 1);
  localparam logic [TW-1:0] T_ALU_A = TW'(LAT_ALU_ADR - 1);
  localparam logic [TW-1:0] T_LD_G  = TW'(LAT_LD_GEN - 1);
  localparam logic [TW-1:0] T_LD_A  = TW'(LAT_LD_ADR - 1);
  localparam logic [TW-1:0] T_MUL_G = TW'(LAT_MUL_GEN - 1);
  localparam logic [TW-1:0] T_MUL_A = TW'(LAT_MUL_ADR - 1);

  logic [NREG-1:0][TW-1:0] gen_t;
  logic [NREG-1:0][TW-1:0] adr_t;

  function automatic logic [TW-1:0] gen_set(input logic [2:0] c);
    case (c)
      CLS_LS, CLS_BLK: return T_LD_G;
      CLS_MUL:         return T_MUL_G;
      default:         return T_ALU_G;
    endcase
  endfunction

  function automatic logic [TW-1:0] adr_set(input logic [2:0] c);
    case (c)
      CLS_LS, CLS_BLK: return T_LD_A;
      CLS_MUL:         return T_MUL_A;
      default:         return T_ALU_A;
    endcase
  endfunction

  // Per register: countdown until ordinary use and until address use
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gen_t <= '0;
      adr_t <= '0;
    end else begin
      for (int r = 0; r < NREG; r++) begin
        if (wr_en_i[0] && wr_reg_i[0] == RW'(r)) begin
          gen_t[r] <= gen_set(wr_cls_i[0]);
          adr_t[r] <= adr_set(wr_cls_i[0]);
        end else if (wr_en_i[1] && wr_reg_i[1] == RW'(r)) begin
          gen_t[r] <= gen_set(wr_cls_i[1]);
          adr_t[r] <= adr_set(wr_cls_i[1]);
        end else begin
          if (gen_t[r] != '0) gen_t[r] <= gen_t[r] - 1'b1;
          if (adr_t[r] != '0) adr_t[r] <= adr_t[r] - 1'b1;
        end
      end
    end
  end

  always_comb begin
    for (int q = 0; q < 4; q++) begin
      rd_rdy_o[q] = rd_adr_i[q] ? (adr_t[rd_reg_i[q]] == '0)
                                : (gen_t[rd_reg_i[q]] == '0);
    end
  end

  AST_SB_DIFF_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i == 2'b11) |-> (wr_reg_i[0] != wr_reg_i[1])); // R5
endmodule

// File: rtl/dual_issue_pair_check.sv
module dual_issue_pair_check
  import dual_issue_pkg::*;
#(
  parameter int RW = 4
) (
  input  logic [2:0]    i0_cls_i,
  input  logic          i0_wr_i,
  input  logic [RW-1:0] i0_dst_i,
  input  logic          i1_vld_i,
  input  logic [2:0]    i1_cls_i,
  input  logic          i1_wr_i,
  input  logic [RW-1:0] i1_dst_i,
  input  logic [RW-1:0] i1_srca_i,
  input  logic [RW-1:0] i1_srcb_i,
  input  logic          i1_src_rdy_i,
  output logic          pair_ok_o
);
  logic mem_clash, br_clash, slot_bad, dst_clash, raw_clash;

  always_comb begin
    mem_clash = is_mem(i0_cls_i) && is_mem(i1_cls_i);
    br_clash  = (i0_cls_i == CLS_BR) && (i1_cls_i == CLS_BR);
    slot_bad  = (i1_cls_i == CLS_MUL) || (i1_cls_i == CLS_BLK);
    dst_clash = i0_wr_i && i1_wr_i && (i0_dst_i == i1_dst_i);
    raw_clash = i0_wr_i && ((i1_srca_i == i0_dst_i) || (i1_srcb_i == i0_dst_i));
    pair_ok_o = i1_vld_i && i1_src_rdy_i && !mem_clash && !br_clash &&
                !slot_bad && !dst_clash && !raw_clash;
  end
endmodule

// File: rtl/dual_issue_blk_seq.sv
module dual_issue_blk_seq #(
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic [CW-1:0] nreg_i,
  output logic          busy_o,
  output logic          last_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] beats;

  // first beat moves one register, later beats two
  assign beats  = CW'(1) + (nreg_i >> 1);
  assign busy_o = (cnt_q != '0);
  assign last_o = busy_o ? (cnt_q == CW'(1)) : (beats == CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (go_i)   cnt_q <= busy_o ? cnt_q - 1'b1 : beats - 1'b1;
  end

  AST_BLK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !go_i) |=> (cnt_q == $past(cnt_q))); // R10
  AST_BLK_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && go_i) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R9
endmodule

// File: rtl/dual_issue_ctrl.sv
module dual_issue_ctrl
  import dual_issue_pkg::*;
#(
  parameter int NREG = 16,
  parameter int CW   = 4,
  parameter int TW   = 2,
  localparam int RW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          stall_i,
  input  logic          i0_vld_i,
  input  logic [2:0]    i0_cls_i,
  input  logic [RW-1:0] i0_dst_i,
  input  logic          i0_wr_i,
  input  logic [RW-1:0] i0_srca_i,
  input  logic [RW-1:0] i0_srcb_i,
  input  logic [CW-1:0] i0_nreg_i,
  input  logic          i1_vld_i,
  input  logic [2:0]    i1_cls_i,
  input  logic [RW-1:0] i1_dst_i,
  input  logic          i1_wr_i,
  input  logic [RW-1:0] i1_srca_i,
  input  logic [RW-1:0] i1_srcb_i,
  output logic          s0_issue_o,
  output logic          s1_issue_o,
  output logic [1:0]    adv_o
);
  logic [3:0]         rdy;
  logic [1:0]         wr_en;
  logic [1:0][RW-1:0] wr_reg;
  logic [1:0][2:0]    wr_cls;
  logic               blk_busy, blk_last, blk_go;
  logic               i0_src_ok, i1_src_ok, i0_done, pair_ok;

  assign wr_reg = {i1_dst_i, i0_dst_i};
  assign wr_cls = {i1_cls_i, i0_cls_i};

  dual_issue_scoreboard #(.NREG(NREG), .TW(TW)) u_sb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .wr_reg_i (wr_reg),
    .wr_cls_i (wr_cls),
    .rd_reg_i ({i1_srcb_i, i1_srca_i, i0_srcb_i, i0_srca_i}),
    .rd_adr_i ({1'b0, is_mem(i1_cls_i), 1'b0, is_mem(i0_cls_i)}),
    .rd_rdy_o (rdy)
  );

  dual_issue_blk_seq #(.CW(CW)) u_blk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (blk_go),
    .nreg_i (i0_nreg_i),
    .busy_o (blk_busy),
    .last_o (blk_last)
  );

  assign i1_src_ok = rdy[2] && rdy[3];

  dual_issue_pair_check #(.RW(RW)) u_pair (
    .i0_cls_i     (i0_cls_i),
    .i0_wr_i      (i0_wr_i),
    .i0_dst_i     (i0_dst_i),
    .i1_vld_i     (i1_vld_i),
    .i1_cls_i     (i1_cls_i),
    .i1_wr_i      (i1_wr_i),
    .i1_dst_i     (i1_dst_i),
    .i1_srca_i    (i1_srca_i),
    .i1_srcb_i    (i1_srcb_i),
    .i1_src_rdy_i (i1_src_ok),
    .pair_ok_o    (pair_ok)
  );

  always_comb begin
    // operands of an ongoing transfer were checked on its first beat
    i0_src_ok  = blk_busy || (rdy[0] && rdy[1]);
    s0_issue_o = (i0_vld_i || blk_busy) && !stall_i && i0_src_ok;
    blk_go     = s0_issue_o && (i0_cls_i == CLS_BLK);
    i0_done    = s0_issue_o && ((i0_cls_i != CLS_BLK) || blk_last);
    s1_issue_o = i0_done && pair_ok;
    adv_o      = {1'b0, i0_done} + {1'b0, s1_issue_o};
    wr_en[0]   = s0_issue_o && !blk_busy && i0_wr_i;
    wr_en[1]   = s1_issue_o && i1_wr_i;
  end

  AST_S1_WITH_S0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_issue_o |-> s0_issue_o); // R1
  AST_ONE_MEM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_issue_o |-> !(is_mem(i0_cls_i) && is_mem(i1_cls_i))); // R2
  AST_NO_MUL_S1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_issue_o |-> (i1_cls_i != CLS_MUL)); // R3
  AST_ONE_BR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_issue_o |-> !((i0_cls_i == CLS_BR) && (i1_cls_i == CLS_BR))); // R4
  AST_DST_DIFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_issue_o && i0_wr_i && i1_wr_i) |-> (i0_dst_i != i1_dst_i)); // R5
  AST_NO_BLK_S1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_issue_o |-> (i1_cls_i != CLS_BLK)); // R8
  AST_BLK_MID_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blk_busy && !blk_last) |-> (adv_o == 2'd0)); // R9
  AST_STALL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |-> (!s0_issue_o && adv_o == 2'd0)); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!i0_vld_i && !blk_busy) |-> !s0_issue_o); // R11
endmodule

// File: tb/dual_issue_ctrl_tb.sv
module dual_issue_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stall = 1'b0;
  logic       v0 = 0, w0 = 0, v1 = 0, w1 = 0;
  logic [2:0] c0 = 0, c1 = 0;
  logic [3:0] d0 = 0, a0 = 0, b0 = 0, n0 = 0, d1 = 0, a1 = 0, b1 = 0;
  logic       s0, s1;
  logic [1:0] adv;
  int         n_chk = 0, n_bad = 0;
  bit         done = 0;

  localparam logic [2:0] ALU = 0, LS = 1, MUL = 2, BR = 3, BLK = 4;
  localparam logic [3:0] RZ = 4'd15; // never written: always ready

  always #5 clk = ~clk;

  dual_issue_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .stall_i(stall),
    .i0_vld_i(v0), .i0_cls_i(c0), .i0_dst_i(d0), .i0_wr_i(w0),
    .i0_srca_i(a0), .i0_srcb_i(b0), .i0_nreg_i(n0),
    .i1_vld_i(v1), .i1_cls_i(c1), .i1_dst_i(d1), .i1_wr_i(w1),
    .i1_srca_i(a1), .i1_srcb_i(b1),
    .s0_issue_o(s0), .s1_issue_o(s1), .adv_o(adv)
  );

  task automatic put0(input logic [2:0] c, input logic [3:0] d, input logic w,
                      input logic [3:0] a, input logic [3:0] b, input logic [3:0] n);
    v0 = 1; c0 = c; d0 = d; w0 = w; a0 = a; b0 = b; n0 = n;
  endtask

  task automatic put1(input logic [2:0] c, input logic [3:0] d, input logic w,
                      input logic [3:0] a, input logic [3:0] b);
    v1 = 1; c1 = c; d1 = d; w1 = w; a1 = a; b1 = b;
  endtask

  task automatic clr();
    v0 = 0; v1 = 0; w0 = 0; w1 = 0; stall = 0;
  endtask

  // inputs were set just after a negedge; check before the next posedge, then step
  task automatic cyc(input logic e0, input logic e1, input logic [1:0] ea, input string req);
    #1;
    n_chk++;
    if (s0 !== e0 || s1 !== e1 || adv !== ea) begin
      n_bad++;
      $display("FAIL %s: s0/s1/adv = %b/%b/%0d expected %b/%b/%0d", req, s0, s1, adv, e0, e1, ea);
    end
    @(negedge clk);
  endtask

  task automatic idle();
    clr();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    cyc(0, 0, 0, "R11 reset idle");
    put0(ALU, 1, 1, RZ, RZ, 0); put1(ALU, 2, 1, RZ, RZ);
    cyc(1, 1, 2, "R1 R11 pair after reset");
    idle();
  endtask

  task automatic t_mem();
    put0(LS, 3, 1, RZ, RZ, 0); put1(LS, 4, 0, RZ, RZ);
    cyc(1, 0, 1, "R2 two loads/stores");
    put0(LS, 3, 1, RZ, RZ, 0); put1(ALU, 5, 1, RZ, RZ);
    cyc(1, 1, 2, "R2 LS then ALU");
    put0(ALU, 6, 1, RZ, RZ, 0); put1(LS, 7, 0, RZ, RZ);
    cyc(1, 1, 2, "R2 ALU then LS");
    idle();
  endtask

  task automatic t_mul();
    put0(ALU, 1, 1, RZ, RZ, 0); put1(MUL, 2, 1, RZ, RZ);
    cyc(1, 0, 1, "R3 MUL younger");
    put0(MUL, 2, 1, RZ, RZ, 0); put1(MUL, 3, 1, RZ, RZ);
    cyc(1, 0, 1, "R3 two MUL");
    put0(MUL, 3, 1, RZ, RZ, 0); put1(ALU, 6, 1, RZ, RZ);
    cyc(1, 1, 2, "R3 MUL slot0 pairs");
    idle();
  endtask

  task automatic t_br();
    put0(BR, 0, 0, RZ, RZ, 0); put1(BR, 0, 0, RZ, RZ);
    cyc(1, 0, 1, "R4 two branches");
    put0(BR, 0, 0, RZ, RZ, 0); put1(ALU, 7, 1, RZ, RZ);
    cyc(1, 1, 2, "R4 branch pairs with ALU");
    idle();
  endtask

  task automatic t_dst();
    put0(ALU, 8, 1, RZ, RZ, 0); put1(ALU, 8, 1, RZ, RZ);
    cyc(1, 0, 1, "R5 same destination");
    put0(ALU, 9, 1, RZ, RZ, 0); put1(ALU, 9, 0, RZ, RZ);
    cyc(1, 1, 2, "R5 younger no write");
    idle();
  endtask

  task automatic t_src();
    put0(ALU, 10, 1, RZ, RZ, 0); put1(ALU, 11, 1, 10, RZ);
    cyc(1, 0, 1, "R6 slot1 reads slot0 result");
    v1 = 0; put0(ALU, 11, 1, 10, RZ, 0);
    cyc(1, 0, 1, "R7 ALU to ALU next cycle");
    idle();
  endtask

  task automatic t_addr();
    put0(ALU, 12, 1, RZ, RZ, 0);
    cyc(1, 0, 1, "R7 producer");
    put0(LS, 13, 1, 12, RZ, 0);
    cyc(0, 0, 0, "R7 address wait 1");
    cyc(0, 0, 0, "R7 address wait 2");
    cyc(1, 0, 1, "R7 address ready");
    idle();
  endtask

  task automatic t_mul_lat();
    put0(MUL, 14, 1, RZ, RZ, 0);
    cyc(1, 0, 1, "R7 MUL producer");
    put0(ALU, 1, 1, 14, RZ, 0);
    cyc(0, 0, 0, "R6 R7 MUL result pending");
    cyc(1, 0, 1, "R7 MUL result ready");
    idle();
  endtask

  task automatic t_blk_young();
    put0(ALU, 1, 1, RZ, RZ, 0); put1(BLK, 2, 1, RZ, RZ);
    cyc(1, 0, 1, "R8 block transfer younger");
    idle();
  endtask

  task automatic t_blk4();
    put0(BLK, 2, 1, RZ, RZ, 4); put1(ALU, 3, 1, RZ, RZ);
    cyc(1, 0, 0, "R9 beat 1 of 3");
    stall = 1;
    cyc(0, 0, 0, "R10 stall mid transfer");
    stall = 0;
    cyc(1, 0, 0, "R9 R10 beat 2 of 3 after stall");
    cyc(1, 1, 2, "R9 last beat pairs");
    idle();
  endtask

  task automatic t_blk_ls();
    put0(BLK, 4, 1, RZ, RZ, 5); put1(LS, 5, 1, RZ, RZ);
    cyc(1, 0, 0, "R9 n=5 beat 1");
    cyc(1, 0, 0, "R9 n=5 beat 2");
    cyc(1, 0, 1, "R2 R9 last beat with younger LS");
    idle();
  endtask

  task automatic t_blk1();
    put0(BLK, 6, 1, RZ, RZ, 1); put1(ALU, 7, 1, RZ, RZ);
    cyc(1, 1, 2, "R9 single beat transfer pairs");
    idle();
  endtask

  task automatic t_stall();
    put0(ALU, 1, 1, RZ, RZ, 0); put1(ALU, 2, 1, RZ, RZ);
    stall = 1;
    cyc(0, 0, 0, "R10 stall blocks pair");
    stall = 0;
    cyc(1, 1, 2, "R10 release");
    idle();
  endtask

  task automatic t_idle();
    clr(); put1(ALU, 2, 1, RZ, RZ);
    cyc(0, 0, 0, "R11 only younger valid");
    idle();
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mem();
    t_mul();
    t_br();
    t_dst();
    t_src();
    t_addr();
    t_mul_lat();
    t_blk_young();
    t_blk4();
    t_blk_ls();
    t_blk1();
    t_stall();
    t_idle();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule